// File: doc/BRIEF.md
# Sparsified Pixel Group Readout Channel

This block drains one group of pixel cells, 256 by default. Each cell holds two hit counters. One of them is readable and the other is accumulating. The block sees one non-zero flag per cell. It always chooses the hit cell with the largest address and reads that cell's count through an external multiplexer steered by the selected address. It then sends the address and the count out as one serial word. After the last bit it pulses a strobe to that one cell, which swaps the cell's counters. The cell is read again for as long as its newly exposed count is non-zero. Otherwise the channel moves down to the next hit cell, until the group is empty.

Each group has its own channel, so many channels can run side by side without sharing anything. A group-level hit flag tells the system whether any cell still holds data. While that flag is low, the serial lane stays quiet.

Top module: `pixel_group_readout`

## Requirements
- R1: While rst_n is low, ser_data, ser_frame, hit_or and every bit of pix_strobe are 0 and sel_addr is 0, even when cells report hits.
- R2: When a new cell has to be chosen, the channel picks the hit cell with the highest address (pix_nz bit index).
- R3: Each word is ADDR_W+CNT_W bits long, 13 by default, and is sent MSB first. The cell address comes first and the 5-bit count second. ser_frame is high for exactly those 13 consecutive cycles, and sel_addr does not change while ser_frame is high.
- R4: One cycle after the last bit of a word, exactly one pix_strobe bit goes high for one cycle. That bit is the bit of the cell whose address was just sent.
- R5: After a strobe, if the selected cell's new count is non-zero, that cell is read again, even when a higher cell became hit in the meantime.
- R6: After a strobe, if the selected cell's new count is zero, the next word comes from the highest remaining hit cell. This repeats until no cell is hit.
- R7: hit_or is a registered OR of pix_nz. It rises one clock after the first flag is set and falls one clock after all flags are clear.
- R8: While hit_or is low, ser_data and ser_frame stay 0 and no strobe is issued.
- R9: When words follow each other, there are exactly 4 cycles with ser_frame low between the last bit of one word and the first bit of the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_nz | input | N_PIX | Per-cell flag: readable counter non-zero |
| pix_cnt | input | CNT_W | Readable count of the cell at sel_addr |
| pix_strobe | output | N_PIX | One-cycle per-cell counter swap pulse |
| sel_addr | output | ADDR_W | Address of the selected cell |
| ser_data | output | 1 | Serial word bit, MSB first |
| ser_frame | output | 1 | High while a word's bits are on ser_data |
| hit_or | output | 1 | Any cell in the group still holds a non-zero count |

## Verification
The bench builds the block with its defaults: 256 cells, a 5-bit count and the two-level encoder split into groups of 16. Those values make both extreme addresses, 255 and 0, reachable, along with the largest count of 31 and hits that fall in different encoder groups. A small model of the cells swaps each cell's counter pair when that cell is strobed, so repeat reads, drain order and a cell that becomes hit in the middle of a read can all be observed on the serial lane.

// File: rtl/pgr_pkg.sv
package pgr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_SHIFT,
      ST_STROBE,
      ST_WAIT
   } rd_state_e;
endpackage

// File: rtl/pgr_prio_enc.sv
module pgr_prio_enc #(
   parameter int N         = 256,
   parameter int AW        = $clog2(N),
   parameter bit TWO_LEVEL = 1'b1,
   parameter int GRP       = 16
) (
   input  logic [N-1:0]  nz,
   output logic [AW-1:0] addr,
   output logic          any
);
   generate
      if (TWO_LEVEL) begin : g_two
         localparam int NG = N / GRP;
         if (N % GRP != 0) begin : g_bad_grp
            $error("pgr_prio_enc: N must be a multiple of GRP");
         end
         logic [NG-1:0] grp_any;
         for (genvar g = 0; g < NG; g++) begin : g_or
            assign grp_any[g] = |nz[g*GRP +: GRP];
         end
         always_comb begin
            int gi;
            int li;
            logic [GRP-1:0] slice;
            gi = 0;
            for (int g = 0; g < NG; g++) begin
               if (grp_any[g]) gi = g;
            end
            slice = nz[gi*GRP +: GRP];
            li = 0;
            for (int j = 0; j < GRP; j++) begin
               if (slice[j]) li = j;
            end
            addr = AW'(gi * GRP + li);
            any  = |grp_any;
         end
      end else begin : g_lin
         always_comb begin
            addr = '0;
            for (int i = 0; i < N; i++) begin
               if (nz[i]) addr = AW'(i);
            end
            any = |nz;
         end
      end
   endgenerate

   always_comb begin
      if (any) begin
         assert_enc_hit_R2 : assert (nz[addr]);
         assert_enc_top_R2 : assert ((nz >> addr) == N'(1));
      end
   end
endmodule

// File: rtl/pgr_serializer.sv
module pgr_serializer #(
   parameter int W = 13
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         shift,
   input  logic [W-1:0] din,
   output logic         msb
);
   logic [W-1:0] sh_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     sh_q <= '0;
      else if (load)  sh_q <= din;
      else if (shift) sh_q <= {sh_q[W-2:0], 1'b0};
   end

   assign msb = sh_q[W-1];
endmodule

// File: rtl/pgr_strobe_dec.sv
module pgr_strobe_dec #(
   parameter int N  = 256,
   parameter int AW = $clog2(N)
) (
   input  logic          en,
   input  logic [AW-1:0] sel,
   output logic [N-1:0]  strobe
);
   for (genvar i = 0; i < N; i++) begin : g_dec
      assign strobe[i] = en && (sel == AW'(i));
   end
endmodule

// File: rtl/pixel_group_readout.sv
module pixel_group_readout
   import pgr_pkg::*;
#(
   parameter int N_PIX     = 256,
   parameter int CNT_W     = 5,
   parameter bit TWO_LEVEL = 1'b1,
   parameter int ENC_GRP   = 16,
   localparam int ADDR_W   = $clog2(N_PIX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PIX-1:0]  pix_nz,
   input  logic [CNT_W-1:0]  pix_cnt,
   output logic [N_PIX-1:0]  pix_strobe,
   output logic [ADDR_W-1:0] sel_addr,
   output logic              ser_data,
   output logic              ser_frame,
   output logic              hit_or
);
   localparam int WORD_W = ADDR_W + CNT_W;
   localparam int BC_W   = $clog2(WORD_W);
   localparam int LEN_W  = BC_W + 1;

   if (N_PIX < 2) begin : g_bad_npix
      $error("pixel_group_readout: N_PIX must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("pixel_group_readout: CNT_W must be at least 1");
   end

   logic [ADDR_W-1:0] enc_addr, enc_addr_q, sel_q;
   logic              enc_any, enc_any_q, sel_hit_q, reread_q;
   logic [BC_W-1:0]   bit_q;
   logic              sh_msb;
   rd_state_e         state_q;

   pgr_prio_enc #(
      .N(N_PIX), .AW(ADDR_W), .TWO_LEVEL(TWO_LEVEL), .GRP(ENC_GRP)
   ) u_enc (
      .nz(pix_nz), .addr(enc_addr), .any(enc_any)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enc_addr_q <= '0;
         enc_any_q  <= 1'b0;
         sel_hit_q  <= 1'b0;
      end else begin
         enc_addr_q <= enc_addr;
         enc_any_q  <= enc_any;
         sel_hit_q  <= pix_nz[sel_q];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         sel_q    <= '0;
         bit_q    <= '0;
         reread_q <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               reread_q <= 1'b0;
               if (enc_any_q) begin
                  sel_q   <= (reread_q && sel_hit_q) ? sel_q : enc_addr_q;
                  state_q <= ST_LOAD;
               end
            end
            ST_LOAD: begin
               bit_q   <= '0;
               state_q <= ST_SHIFT;
            end
            ST_SHIFT: begin
               if (bit_q == BC_W'(WORD_W - 1)) state_q <= ST_STROBE;
               else                            bit_q   <= bit_q + 1'b1;
            end
            ST_STROBE: state_q <= ST_WAIT;
            ST_WAIT: begin
               reread_q <= 1'b1;
               state_q  <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   pgr_serializer #(.W(WORD_W)) u_ser (
      .clk(clk), .rst_n(rst_n),
      .load(state_q == ST_LOAD),
      .shift(state_q == ST_SHIFT),
      .din({sel_q, pix_cnt}),
      .msb(sh_msb)
   );

   pgr_strobe_dec #(.N(N_PIX), .AW(ADDR_W)) u_stb (
      .en(state_q == ST_STROBE), .sel(sel_q), .strobe(pix_strobe)
   );

   assign sel_addr  = sel_q;
   assign ser_frame = (state_q == ST_SHIFT);
   assign ser_data  = (state_q == ST_SHIFT) && sh_msb;
   assign hit_or    = enc_any_q;

   // frame length watch for the word-size property
   logic [LEN_W-1:0] frame_len_q;
   always_ff @(posedge clk) begin
      if (!rst_n)         frame_len_q <= '0;
      else if (ser_frame) frame_len_q <= frame_len_q + 1'b1;
      else                frame_len_q <= '0;
   end

   assert_frame_len_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_frame) |-> (frame_len_q == LEN_W'(WORD_W)));
   assert_addr_stable_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (ser_frame && $past(ser_frame)) |-> $stable(sel_addr));
   assert_strobe_onehot_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pix_strobe));
   assert_strobe_after_word_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (pix_strobe != '0) |-> ($past(ser_frame) && !ser_frame));
   assert_quiet_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !hit_or |-> (!ser_data && !ser_frame && pix_strobe == '0));
endmodule

// File: tb/pixel_group_readout_tb.sv
`timescale 1ns/1ps
module pixel_group_readout_tb;
   localparam int NP = 256;
   localparam int CW = 5;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pix_nz;
   logic [CW-1:0] pix_cnt;
   logic [NP-1:0] pix_strobe;
   logic [AW-1:0] sel_addr;
   logic          ser_data, ser_frame, hit_or;

   bit [CW-1:0] cur [NP];
   bit [CW-1:0] nxt [NP];

   always #2.5 clk = ~clk;

   for (genvar g = 0; g < NP; g++) begin : g_flag
      assign pix_nz[g] = (cur[g] != '0);
   end
   assign pix_cnt = cur[sel_addr];

   pixel_group_readout u_dut (
      .clk(clk), .rst_n(rst_n), .pix_nz(pix_nz), .pix_cnt(pix_cnt),
      .pix_strobe(pix_strobe), .sel_addr(sel_addr), .ser_data(ser_data),
      .ser_frame(ser_frame), .hit_or(hit_or)
   );

   // {addr, first count, second count}; first count 0 marks an unused slot
   localparam logic [17:0] VEC [12] = '{
      {8'd255, 5'd5,  5'd0}, {8'd0,   5'd31, 5'd0}, {8'd128, 5'd1,  5'd3},
      {8'd10,  5'd7,  5'd7}, {8'd9,   5'd2,  5'd0}, {8'd11,  5'd31, 5'd1},
      {8'd3,   5'd1,  5'd0}, {8'd2,   5'd1,  5'd0}, {8'd1,   5'd1,  5'd0},
      {8'd77,  5'd16, 5'd0}, {8'd78,  5'd0,  5'd0}, {8'd76,  5'd30, 5'd30}
   };

   int n_cmp = 0, n_bad = 0;
   logic [12:0] got [64];
   logic [12:0] expw [64];
   int ngot, nexp, nbits, low_run;
   logic [12:0] word;
   bit prev_frame;

   task automatic check(input bit ok, input string req, input int act, input int exv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exv);
      end
   endtask

   task automatic clear_words();
      ngot = 0; nbits = 0; word = '0; low_run = 0;
   endtask

   task automatic build_expected();
      bit [CW-1:0] ec [NP];
      bit [CW-1:0] en [NP];
      int last;
      int pick;
      for (int i = 0; i < NP; i++) begin ec[i] = cur[i]; en[i] = nxt[i]; end
      last = -1; nexp = 0;
      while (nexp < 64) begin
         pick = -1;
         if (last >= 0 && ec[last] != 0) pick = last;
         else for (int i = 0; i < NP; i++) if (ec[i] != 0) pick = i;
         if (pick < 0) break;
         expw[nexp] = {pick[7:0], ec[pick]};
         nexp++;
         ec[pick] = en[pick]; en[pick] = '0;
         last = pick;
      end
   endtask

   task automatic tick();
      int sidx;
      bit spend;
      spend = 1'b0; sidx = 0;
      @(negedge clk);
      if (ser_frame) begin
         if (!prev_frame && ngot > 0)
            check(low_run == 4, "R9 gap between words", low_run, 4);
         word = {word[11:0], ser_data};
         nbits++;
         low_run = 0;
      end else begin
         if (nbits > 0) begin
            check(nbits == 13, "R3 word length", nbits, 13);
            if (ngot < 64) begin got[ngot] = word; ngot++; end
            nbits = 0; word = '0;
         end
         low_run++;
      end
      if (pix_strobe != '0) begin
         for (int i = 0; i < NP; i++) if (pix_strobe[i]) sidx = i;
         check($countones(pix_strobe) == 1, "R4 strobe one-hot", $countones(pix_strobe), 1);
         check(prev_frame && !ser_frame, "R4 strobe right after last bit", prev_frame, 1);
         if (ngot > 0)
            check(sidx == int'(got[ngot-1][12:5]), "R4 strobe target", sidx, int'(got[ngot-1][12:5]));
         spend = 1'b1;
      end
      if (!hit_or)
         check(!ser_data && !ser_frame && pix_strobe == '0, "R8 quiet while no hit",
               int'(ser_frame), 0);
      prev_frame = ser_frame;
      @(posedge clk);
      #1;
      if (spend) begin cur[sidx] = nxt[sidx]; nxt[sidx] = '0; end
   endtask

   task automatic compare_words(input string req);
      check(ngot == nexp, req, ngot, nexp);
      for (int i = 0; i < nexp && i < ngot; i++)
         check(got[i] == expw[i], req, int'(got[i]), int'(expw[i]));
   endtask

   task automatic drain();
      int guard;
      guard = 0;
      while (ngot < nexp && guard < 3000) begin tick(); guard++; end
      repeat (6) tick();
   endtask

   initial begin
      bit injected;
      // R1: reset with a hit present
      cur[200] = 5'd3;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(hit_or == 1'b0, "R1 hit_or in reset", int'(hit_or), 0);
      check(ser_frame == 1'b0 && ser_data == 1'b0, "R1 serial in reset", int'(ser_frame), 0);
      check(pix_strobe == '0, "R1 strobe in reset", $countones(pix_strobe), 0);
      check(sel_addr == '0, "R1 sel_addr in reset", int'(sel_addr), 0);
      clear_words(); prev_frame = 1'b0;
      build_expected();
      @(posedge clk); #1;
      rst_n = 1'b1;
      drain();
      compare_words("R2 R6 word after reset");

      // table-driven scenarios
      for (int s = 0; s < 4; s++) begin
         clear_words();
         for (int k = 0; k < 3; k++) begin
            logic [17:0] v;
            v = VEC[s*3 + k];
            if (v[9:5] != '0) begin
               cur[v[17:10]] = v[9:5];
               nxt[v[17:10]] = v[4:0];
            end
         end
         build_expected();
         @(negedge clk);
         check(hit_or == 1'b0, "R7 hit_or one clock late", int'(hit_or), 0);
         @(negedge clk);
         check(hit_or == 1'b1, "R7 hit_or rises", int'(hit_or), 1);
         drain();
         compare_words("R2 R3 R6 table words");
         check(hit_or == 1'b0, "R7 hit_or low after drain", int'(hit_or), 0);
      end

      // R5: a higher cell becomes hit while the current cell is mid-word
      clear_words();
      cur[50] = 5'd4; nxt[50] = 5'd6;
      nexp = 3;
      expw[0] = {8'd50, 5'd4}; expw[1] = {8'd50, 5'd6}; expw[2] = {8'd60, 5'd9};
      injected = 1'b0;
      for (int t = 0; t < 3000 && ngot < nexp; t++) begin
         tick();
         if (!injected && ngot == 0 && nbits == 5) begin
            cur[60] = 5'd9; injected = 1'b1;
         end
      end
      repeat (6) tick();
      compare_words("R5 same cell re-read before higher cell");

      // R8: long quiet period with no hits
      clear_words();
      repeat (20) tick();
      check(ngot == 0 && hit_or == 1'b0, "R8 no words while empty", ngot, 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule